// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer

This block holds three independent 16-bit up-counters behind a single byte-addressed register port. Each channel counts ticks from a shared prescaler. A channel can return to zero when it reaches its compare value, which gives a periodic event with a period of compare + 1 ticks. On each match it can drive a dedicated output pin low, high or to the opposite level. The match sets a status flag, and so does a counter wrap. Either flag, when enabled, raises the channel's interrupt line.

One shared run register starts and halts the channels, one bit per channel. Software clears a status flag in two steps: it first reads the status register while the flag is set, and then writes 0 to that bit. Only normal up-counting is provided. A mode register exists and can be read back, but it has no effect.

Top module: `cmt_unit`

## Requirements
- R1: The run register sits at byte address 0x280. Bit n (n = 0..2) set to 1 runs channel n and set to 0 halts it. A halted counter holds its value. Reading the register returns the three bits in bits 2:0 and zeros above them.
- R2: The channel windows start at 0x300 (channel 0), 0x380 (channel 1) and 0x000 (channel 2). Within a window the offsets are: 0 control, 1 mode, 2 pin control, 4 interrupt enable, 5 status, 6 counter (16-bit) and 8 compare (16-bit). Byte registers take and return bits 7:0. A read with rd_en low, or of an unmapped address, returns 0. After reset every register is 0 except compare, which is 0xFFFF.
- R3: Control bits 2:0 select the tick. Values 0, 1, 2 and 3 give a tick on each cycle in which the low 0, 2, 4 or 6 bits of a free-running cycle count are all ones. That count is 0 in the first cycle after reset is released. Values 4 to 7 give no ticks. A running channel adds one to its counter per tick.
- R4: With control bits 7:5 equal to 1, a tick that finds the counter equal to compare loads 0 instead of incrementing. Every other value of bits 7:5 never clears the counter.
- R5: A tick that finds the counter equal to compare sets status bit 0, whatever the clear setting.
- R6: A tick that finds the counter at 0xFFFF, and does not clear it by R4, wraps the counter to 0 and sets status bit 4.
- R7: The low nibble of the pin control register sets the pin's behaviour. Codes 1, 2 and 3 drive the pin to 0 when written. Codes 5, 6 and 7 drive it to 1 when written. On each compare match, codes 1 and 5 clear the pin, 2 and 6 set it, and 3 and 7 toggle it. All other codes leave the pin as it is.
- R8: The interrupt line is high while status bit 0 and enable bit 0 are both 1, or while status bit 4 and enable bit 4 are both 1. It is registered through the flags, so it follows them in the cycle after the flag changes.
- R9: Writing 0 to a status bit clears it only when a status read made while that bit was 1 has come before the write. Any status write uses up that read.
- R10: Writing 1 to a status bit leaves it unchanged. A flag that sets in the same cycle as a valid clear write ends up set.
- R11: A write to the counter takes effect in place of any tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 10 | Byte address |
| wdata | input | 16 | Write data; byte registers use bits 7:0 |
| rdata | output | 16 | Read data, combinational from addr while rd_en is high |
| cmp_out | output | 3 | Compare output pin per channel |
| irq | output | 3 | Interrupt line per channel |

## Verification
Most internal state of a channel is visible only through its pin, its interrupt line and register reads. A counter that has gone wrong shows up at the next match as a pin edge or flag in the wrong cycle, so the bench checks pin and interrupt against its model on every clock. It also reads the counter back while the channel runs. A wrong arm bit or a lost flag shows up one cycle after the clearing write, as an interrupt line that differs from the model. Mis-decoded addresses show up in the read-back comparisons.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int NCH      = 3;
    localparam int AW       = 10;
    localparam int DW       = 16;
    localparam int NDIV     = 4;               // prescaler taps: /1 /4 /16 /64
    localparam int SEL_W    = $clog2(NDIV);
    localparam int PRE_W    = 2 * (NDIV - 1);
    localparam logic [AW-1:0] RUN_ADDR = 10'h280;

    localparam logic [3:0] OFF_CTRL = 4'd0;
    localparam logic [3:0] OFF_MODE = 4'd1;
    localparam logic [3:0] OFF_PIN  = 4'd2;
    localparam logic [3:0] OFF_IEN  = 4'd4;
    localparam logic [3:0] OFF_STAT = 4'd5;
    localparam logic [3:0] OFF_CNT  = 4'd6;
    localparam logic [3:0] OFF_CMP  = 4'd8;

    function automatic logic [AW-1:0] win_base(input int idx);
        case (idx)
            0:       return 10'h300;
            1:       return 10'h380;
            default: return 10'h000;
        endcase
    endfunction

    typedef struct packed {
        logic [7:0]    ctrl;
        logic [7:0]    mode;
        logic [7:0]    pinc;
        logic [7:0]    ien;
        logic [DW-1:0] cnt;
        logic [DW-1:0] cmp;
        logic          f_match;
        logic          f_wrap;
        logic          arm_match;
        logic          arm_wrap;
        logic          pin;
    } chan_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [NDIV-1:0] tick
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    generate
        for (genvar k = 0; k < NDIV; k++) begin : g_tap
            if (k == 0) begin : g_full
                assign tick[k] = 1'b1;
            end else begin : g_div
                assign tick[k] = &div_q[2*k-1:0];
            end
        end
    endgenerate

    // R3: the slowest tap never fires on two cycles in a row
    a_r3_slow_tap_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick[NDIV-1] |=> !tick[NDIV-1]);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDIV-1:0] tick_i,
    input  logic            run_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [3:0]      off_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            pin_o,
    output logic            irq_o
);
    chan_t ch_d, ch_q;
    logic  tick, hit, clr, wrap;
    logic [2:0] csel;

    always_comb begin
        ch_d = ch_q;
        csel = ch_q.ctrl[2:0];
        tick = run_i && (csel < 3'(NDIV)) && tick_i[csel[SEL_W-1:0]];
        hit  = tick && (ch_q.cnt == ch_q.cmp);
        clr  = hit && (ch_q.ctrl[7:5] == 3'd1);
        wrap = tick && !clr && (ch_q.cnt == '1);

        if (clr)       ch_d.cnt = '0;
        else if (tick) ch_d.cnt = ch_q.cnt + 1'b1;

        if (hit && !ch_q.pinc[3] && (ch_q.pinc[1:0] != 2'd0)) begin
            case (ch_q.pinc[1:0])
                2'd1:    ch_d.pin = 1'b0;
                2'd2:    ch_d.pin = 1'b1;
                default: ch_d.pin = !ch_q.pin;
            endcase
        end

        if (rd_i && off_i == OFF_STAT) begin
            ch_d.arm_match = ch_q.f_match;
            ch_d.arm_wrap  = ch_q.f_wrap;
        end

        if (wr_i) begin
            case (off_i)
                OFF_CTRL: ch_d.ctrl = wdata_i[7:0];
                OFF_MODE: ch_d.mode = wdata_i[7:0];
                OFF_PIN: begin
                    ch_d.pinc = wdata_i[7:0];
                    if (!wdata_i[3] && wdata_i[1:0] != 2'd0) ch_d.pin = wdata_i[2];
                end
                OFF_IEN:  ch_d.ien = wdata_i[7:0];
                OFF_STAT: begin
                    if (!wdata_i[0] && ch_q.arm_match) ch_d.f_match = 1'b0;
                    if (!wdata_i[4] && ch_q.arm_wrap)  ch_d.f_wrap  = 1'b0;
                    ch_d.arm_match = 1'b0;
                    ch_d.arm_wrap  = 1'b0;
                end
                OFF_CNT:  ch_d.cnt = wdata_i;
                OFF_CMP:  ch_d.cmp = wdata_i;
                default: ;
            endcase
        end

        if (hit)  ch_d.f_match = 1'b1;
        if (wrap) ch_d.f_wrap  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q     <= '0;
            ch_q.cmp <= '1;
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (off_i)
                OFF_CTRL: rdata_o = {8'h00, ch_q.ctrl};
                OFF_MODE: rdata_o = {8'h00, ch_q.mode};
                OFF_PIN:  rdata_o = {8'h00, ch_q.pinc};
                OFF_IEN:  rdata_o = {8'h00, ch_q.ien};
                OFF_STAT: rdata_o = {11'd0, ch_q.f_wrap, 3'd0, ch_q.f_match};
                OFF_CNT:  rdata_o = ch_q.cnt;
                OFF_CMP:  rdata_o = ch_q.cmp;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign pin_o = ch_q.pin;
    assign irq_o = (ch_q.f_match && ch_q.ien[0]) || (ch_q.f_wrap && ch_q.ien[4]);

    // R1: a halted channel with no counter write keeps its count
    a_r1_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !(wr_i && off_i == OFF_CNT)) |=> $stable(ch_q.cnt));
    // R4: clear-on-match loads zero
    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(wr_i && off_i == OFF_CNT)) |=> (ch_q.cnt == '0));
    // R5: a match leaves the match flag set
    a_r5_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ch_q.f_match);
    // R6: a wrap leaves the wrap flag set
    a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ch_q.f_wrap);
    // R9: an unarmed flag cannot fall
    a_r9_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.f_match && !ch_q.arm_match) |=> ch_q.f_match);
endmodule

// File: rtl/cmt_unit.sv
module cmt_unit
    import cmt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [9:0]     addr,
    input  logic [15:0]    wdata,
    output logic [15:0]    rdata,
    output logic [2:0]     cmp_out,
    output logic [2:0]     irq
);
    logic [NDIV-1:0] tick;
    logic [NCH-1:0]  run_d, run_q;
    logic [NCH-1:0]  hit;
    logic [DW-1:0]   ch_rdata [NCH];
    logic            run_sel;

    cmt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        run_sel = (addr == RUN_ADDR);
        run_d   = run_q;
        if (wr_en && run_sel) run_d = wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam logic [AW-1:0] BASE = win_base(i);
            assign hit[i] = (addr[AW-1:4] == BASE[AW-1:4]);
            cmt_channel u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (tick),
                .run_i   (run_q[i]),
                .wr_i    (wr_en && hit[i]),
                .rd_i    (rd_en && hit[i]),
                .off_i   (addr[3:0]),
                .wdata_i (wdata),
                .rdata_o (ch_rdata[i]),
                .pin_o   (cmp_out[i]),
                .irq_o   (irq[i])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (rd_en && run_sel) rdata = DW'(run_q);
        for (int i = 0; i < NCH; i++) rdata = rdata | ch_rdata[i];
    end

    // R1: a run-register write lands in the run bits
    a_r1_run_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_sel) |=> (run_q == $past(wdata[NCH-1:0])));
    // R2: at most one window decodes an address
    a_r2_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/tb_cmt_unit.sv
module tb_cmt_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [9:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic [2:0]  cmp_out, irq;

    int checks = 0, failures = 0;
    bit done = 0;

    cmt_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .cmp_out(cmp_out), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model
    logic [7:0]  m_ctrl[3], m_mode[3], m_pinc[3], m_ien[3];
    logic [15:0] m_cnt[3], m_cmp[3];
    bit          m_fm[3], m_fw[3], m_am[3], m_aw[3], m_pin[3];
    logic [2:0]  m_run;
    int          m_cyc;

    function automatic int base_of(int c);
        return (c == 0) ? 'h300 : (c == 1) ? 'h380 : 'h000;
    endfunction

    function automatic logic [15:0] m_read(logic [9:0] a);
        if (a == 10'h280) return {13'd0, m_run};
        for (int c = 0; c < 3; c++) begin
            if ((int'(a) & 'h3F0) == base_of(c)) begin
                case (int'(a) & 'hF)
                    0: return {8'd0, m_ctrl[c]};
                    1: return {8'd0, m_mode[c]};
                    2: return {8'd0, m_pinc[c]};
                    4: return {8'd0, m_ien[c]};
                    5: return {11'd0, m_fw[c], 3'd0, m_fm[c]};
                    6: return m_cnt[c];
                    8: return m_cmp[c];
                    default: return 16'd0;
                endcase
            end
        end
        return 16'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_ctrl[c] = 0; m_mode[c] = 0; m_pinc[c] = 0; m_ien[c] = 0;
                m_cnt[c] = 0; m_cmp[c] = 16'hFFFF;
                m_fm[c] = 0; m_fw[c] = 0; m_am[c] = 0; m_aw[c] = 0; m_pin[c] = 0;
            end
            m_run = 0; m_cyc = 0;
        end else begin
            for (int c = 0; c < 3; c++) begin
                int  sel, per, off;
                bit  tk, mt, cl, wr_, sel_c, set_m, set_w;
                sel = int'(m_ctrl[c][2:0]);
                per = (sel < 4) ? (1 << (2*sel)) : 1;
                tk  = m_run[c] && sel < 4 && ((m_cyc % per) == per - 1);
                mt  = tk && m_cnt[c] == m_cmp[c];
                cl  = mt && m_ctrl[c][7:5] == 3'd1;
                set_m = mt;
                set_w = tk && !cl && m_cnt[c] == 16'hFFFF;
                sel_c = (int'(addr) & 'h3F0) == base_of(c);
                off = int'(addr) & 'hF;
                wr_ = wr_en && sel_c;
                if (mt) begin
                    case (m_pinc[c][3:0])
                        1, 5: m_pin[c] = 0;
                        2, 6: m_pin[c] = 1;
                        3, 7: m_pin[c] = !m_pin[c];
                        default: ;
                    endcase
                end
                if (cl) m_cnt[c] = 0; else if (tk) m_cnt[c] = m_cnt[c] + 16'd1;
                if (rd_en && sel_c && off == 5) begin m_am[c] = m_fm[c]; m_aw[c] = m_fw[c]; end
                if (wr_) begin
                    case (off)
                        0: m_ctrl[c] = wdata[7:0];
                        1: m_mode[c] = wdata[7:0];
                        2: begin
                            m_pinc[c] = wdata[7:0];
                            if (wdata[3:0] inside {1, 2, 3}) m_pin[c] = 0;
                            if (wdata[3:0] inside {5, 6, 7}) m_pin[c] = 1;
                        end
                        4: m_ien[c] = wdata[7:0];
                        5: begin
                            if (!wdata[0] && m_am[c]) m_fm[c] = 0;
                            if (!wdata[4] && m_aw[c]) m_fw[c] = 0;
                            m_am[c] = 0; m_aw[c] = 0;
                        end
                        6: m_cnt[c] = wdata;
                        8: m_cmp[c] = wdata;
                        default: ;
                    endcase
                end
                if (set_m) m_fm[c] = 1;
                if (set_w) m_fw[c] = 1;
            end
            if (wr_en && addr == 10'h280) m_run = wdata[2:0];
            m_cyc++;
        end
    end

    // per-clock port comparison (R7 pin, R8 interrupt)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 3; c++) begin
                bit eirq;
                eirq = (m_fm[c] && m_ien[c][0]) || (m_fw[c] && m_ien[c][4]);
                checks++;
                if (cmp_out[c] !== m_pin[c]) begin
                    failures++;
                    $display("FAIL R7 ch%0d pin actual=%0b expected=%0b", c, cmp_out[c], m_pin[c]);
                end
                checks++;
                if (irq[c] !== eirq) begin
                    failures++;
                    $display("FAIL R8 ch%0d irq actual=%0b expected=%0b", c, irq[c], eirq);
                end
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 10'(a); wdata = 16'(d); wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        addr = 10'(a); rd_en = 1;
        #1;
        checks++;
        if (rdata !== m_read(addr)) begin
            failures++;
            $display("FAIL %s addr=%03h actual=%04h expected=%04h", tag, a, rdata, m_read(addr));
        end
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset values and decode
        rd('h308, "R2"); rd('h305, "R2"); rd('h280, "R1");
        wr('h381, 'hA5); rd('h381, "R2"); rd('h001, "R2"); rd('h30C, "R2");
        // check read returns 0 without rd_en
        checks++;
        if (rdata !== 16'd0) begin failures++; $display("FAIL R2 idle rdata actual=%04h expected=0000", rdata); end

        // channel 0: /1, clear on match at 5, toggle from 0, match irq
        wr('h308, 5); wr('h300, 'h20); wr('h302, 'h03); wr('h304, 'h01);
        wr('h280, 'h1);
        idle(20); rd('h306, "R4"); rd('h306, "R3");
        wr('h305, 'h00);                 // R9: no prior read -> stays set
        rd('h305, "R9");
        wr('h300, 'h24);                 // R3: code 4 stops ticks
        idle(3); rd('h306, "R3");
        rd('h305, "R9"); wr('h305, 'h00); // read then clear
        rd('h305, "R9");
        wr('h305, 'h11); rd('h305, "R10");

        // R10: set wins over clear (match every tick)
        wr('h308, 0); wr('h300, 'h20); idle(2);
        rd('h305, "R10"); wr('h305, 'h00); rd('h305, "R10");

        // channel 1: /4, no clear, start high and clear on match
        wr('h388, 3); wr('h382, 'h05); wr('h384, 'h01); wr('h380, 'h01);
        wr('h280, 'h3);
        idle(30); rd('h386, "R3");
        wr('h380, 'h02); idle(70); rd('h386, "R3");
        wr('h380, 'h03); idle(140); rd('h386, "R3");
        wr('h382, 'h06); wr('h388, 16'h0040); idle(40);
        wr('h382, 'h04); idle(10);       // R7 code 4 keeps pin

        // channel 2: /1, wrap near top, wrap interrupt
        wr('h008, 16'h0100); wr('h004, 'h10); wr('h006, 16'hFFF8);
        wr('h280, 'h7);
        idle(12); rd('h005, "R6"); rd('h006, "R6");
        wr('h005, 'h01); rd('h005, "R6");
        // R11: counter write during ticking
        wr('h006, 16'h1234); rd('h006, "R11");
        // compare at 0xFFFF with clear: clear wins, no wrap flag
        wr('h005, 'h00);
        wr('h00F, 0); wr('h008, 16'hFFFF); wr('h000, 'h20); wr('h006, 16'hFFFD);
        idle(6); rd('h005, "R4"); rd('h006, "R4");

        // R1: halt all, counters hold
        wr('h280, 'h0); rd('h306, "R1"); idle(10); rd('h306, "R1"); rd('h386, "R1");
        rd('h280, "R1");
        idle(5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule